// File: doc/BRIEF.md
# Nonvolatile Store Trigger

This block sits beside an asynchronous SRAM front end and watches every completed chip-enable-controlled access, presented to it as a one-cycle strobe carrying the address and a read/write flag. A fixed unlock code of six reads, in a fixed order, starts a nonvolatile save. The save is modelled as two timed phases: the shadow array is erased, then the SRAM contents are programmed into it. From the first erase cycle until the last program cycle the memory interface is locked out, and access is then given back.

Any access that does not continue the code throws the detector back to its idle state. A write always has this effect. A read also has this effect if its address is not the next expected code word. A read of the first code word is the one exception: it is taken as step one of a fresh attempt. The output enable plays no part, so the block has no pin for it. A supply-fail input starts the same save sequence on its own, blocks the interface for as long as it is high, and clears any partly entered code.

Tracker states are `TS_IDLE`, `TS_GOT1` … `TS_GOT5`, where `TS_GOTn` means n code words have been matched. The tracker transitions are *advance* (the expected word is read), *fire* (the sixth word is read in `TS_GOT5`, which returns the tracker to `TS_IDLE`), *restart* (a read of the first word that does not continue the code moves to `TS_GOT1`), *abort* (any other accepted access moves to `TS_IDLE`) and *clear* (busy or supply fail moves to `TS_IDLE`). Sequencer states are `ST_READY`, `ST_ERASE` and `ST_PROGRAM`. Its transitions are *launch* (`ST_READY` to `ST_ERASE` on fire or on a supply-fail rising edge), *handover* (`ST_ERASE` to `ST_PROGRAM` when the erase count runs out) and *release* (`ST_PROGRAM` to `ST_READY` when the program count runs out).

Top module: `nv_store_trigger`

## Requirements
- R1: Accepted reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F, with no other accepted access between them, raise `busy` and `erase_on` in the cycle after the sixth read is sampled.
- R2: An accepted write (`acc_we`=1) at any point of the code returns the detector to idle, and no save follows.
- R3: An accepted read whose address is not the next code word aborts the attempt. If that address is 0x0000, it counts as step one of a new attempt.
- R4: A save holds `erase_on` for exactly ERASE_CYC cycles and then `prog_on` for exactly PROG_CYC cycles. The two are never high together, and `busy` covers both phases.
- R5: While `busy` is high, `access_en` is low, and strobes are ignored: they neither advance the code nor leave partial progress behind.
- R6: A rising edge on `pwr_fail` while not busy starts a save on the next cycle. While `pwr_fail` is high, `access_en` is low and accesses are ignored. A supply fail also discards a partly entered code.
- R7: After reset, `busy`, `erase_on` and `prog_on` are low, `access_en` is high and the detector is idle.
- R8: When a save finishes, `access_en` returns to high (if `pwr_fail` is low), and a further complete code starts another save.
- R9: Holding `pwr_fail` high through and after a save does not start a second save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | One-cycle strobe marking a completed chip-enable access |
| acc_we | input | 1 | 1 = the access was a write, 0 = a read |
| acc_addr | input | ADDR_W | Address of the access |
| pwr_fail | input | 1 | Supply below the switch threshold |
| access_en | output | 1 | Memory interface open for reads and writes |
| busy | output | 1 | A save is in progress |
| erase_on | output | 1 | Erase phase active |
| prog_on | output | 1 | Program phase active |

## Verification
The assertions check on every cycle that erase and program are mutually exclusive, that the interface is locked while busy, that each phase lasts exactly its parameter length, that a write or a stray read drops the tracker to idle or to step one, and that a fire or a supply-fail edge starts an erase on the next cycle. Only the bench scenarios can show the end-to-end properties. These are that long random access streams produce a save exactly when the full code appears, that strobes during a save or a supply fail leave no partial progress, and that a supply fail held high causes no second save.

// File: rtl/nv_store_pkg.sv
package nv_store_pkg;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_GOT1 = 3'd1,
        TS_GOT2 = 3'd2,
        TS_GOT3 = 3'd3,
        TS_GOT4 = 3'd4,
        TS_GOT5 = 3'd5
    } trk_state_t;

    typedef enum logic [1:0] {
        ST_READY   = 2'd0,
        ST_ERASE   = 2'd1,
        ST_PROGRAM = 2'd2
    } seq_state_t;

    localparam int CODE_LEN = 6;

    // Code word expected when `matched` words have already been seen.
    function automatic logic [15:0] code_word(input logic [2:0] matched);
        logic [15:0] w;
        unique case (matched)
            3'd0:    w = 16'h0000;
            3'd1:    w = 16'h1555;
            3'd2:    w = 16'h0AAA;
            3'd3:    w = 16'h1FFF;
            3'd4:    w = 16'h10F0;
            3'd5:    w = 16'h0F0F;
            default: w = 16'hFFFF;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/code_tracker.sv
module code_tracker
    import nv_store_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              acc_ok,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              fire
);

    localparam logic [ADDR_W-1:0] FIRST_WORD = ADDR_W'(16'h0000);

    trk_state_t state_q, state_d;
    logic [ADDR_W-1:0] want;
    logic              is_read, hit, restart;

    always_comb begin
        want    = ADDR_W'(code_word(state_q));
        is_read = acc_ok && !acc_we;
        hit     = is_read && (acc_addr == want);
        restart = is_read && (acc_addr == FIRST_WORD);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TS_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: clear, advance, fire, restart, abort
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = TS_IDLE;
        end else if (acc_ok) begin
            if (hit) begin
                unique case (state_q)
                    TS_IDLE: state_d = TS_GOT1;
                    TS_GOT1: state_d = TS_GOT2;
                    TS_GOT2: state_d = TS_GOT3;
                    TS_GOT3: state_d = TS_GOT4;
                    TS_GOT4: state_d = TS_GOT5;
                    TS_GOT5: state_d = TS_IDLE;
                    default: state_d = TS_IDLE;
                endcase
            end else if (restart) begin
                state_d = TS_GOT1;
            end else begin
                state_d = TS_IDLE;
            end
        end
    end

    // Output
    always_comb begin
        fire = !clr && hit && (state_q == TS_GOT5);
    end

    // R2: an accepted write always drops progress
    p_write_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && acc_we && !clr) |=> (state_q == TS_IDLE));

    // R3: a stray read of the first word restarts at step one
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && !acc_we && !clr && acc_addr == FIRST_WORD && state_q != TS_IDLE)
        |=> (state_q == TS_GOT1));

    // R1: a completed code leaves the tracker idle
    p_fire_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (state_q == TS_IDLE));

endmodule

// File: rtl/save_sequencer.sv
module save_sequencer
    import nv_store_pkg::*;
#(
    parameter int ERASE_CYC = 40,
    parameter int PROG_CYC  = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic erase_on,
    output logic prog_on
);

    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] E_LOAD = CW'(ERASE_CYC - 1);
    localparam logic [CW-1:0] P_LOAD = CW'(PROG_CYC - 1);

    seq_state_t      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions: launch, handover, release
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_READY: begin
                if (start) begin
                    state_d = ST_ERASE;
                    cnt_d   = E_LOAD;
                end
            end
            ST_ERASE: begin
                if (cnt_q == '0) begin
                    state_d = ST_PROGRAM;
                    cnt_d   = P_LOAD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_PROGRAM: begin
                if (cnt_q == '0) state_d = ST_READY;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: begin
                state_d = ST_READY;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        erase_on = 1'b0;
        prog_on  = 1'b0;
        unique case (state_q)
            ST_READY:   ;
            ST_ERASE:   erase_on = 1'b1;
            ST_PROGRAM: prog_on  = 1'b1;
            default:    ;
        endcase
        busy = erase_on || prog_on;
    end

    // Phase-length monitor for the assertions below
    int unsigned phase_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  phase_len <= 0;
        else if (state_d != state_q) phase_len <= 1;
        else if (phase_len < 32'hFFFF_FFF0) phase_len <= phase_len + 1;
    end

    p_erase_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_on && state_d == ST_PROGRAM) |-> (phase_len == ERASE_CYC));

    p_prog_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_on && state_d == ST_READY) |-> (phase_len == PROG_CYC));

    p_erase_then_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_on) |-> prog_on);

endmodule

// File: rtl/nv_store_trigger.sv
module nv_store_trigger #(
    parameter int ADDR_W    = 13,
    parameter int ERASE_CYC = 40,
    parameter int PROG_CYC  = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              pwr_fail,
    output logic              access_en,
    output logic              busy,
    output logic              erase_on,
    output logic              prog_on
);

    logic pf_q, pf_rise, acc_ok, trk_clr, code_fire, launch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pf_q <= 1'b0;
        else        pf_q <= pwr_fail;
    end

    always_comb begin
        access_en = !busy && !pwr_fail;
        acc_ok    = acc_valid && access_en;
        trk_clr   = busy || pwr_fail;
        pf_rise   = pwr_fail && !pf_q;
        launch    = code_fire || pf_rise;
    end

    code_tracker #(.ADDR_W(ADDR_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (trk_clr),
        .acc_ok   (acc_ok),
        .acc_we   (acc_we),
        .acc_addr (acc_addr),
        .fire     (code_fire)
    );

    save_sequencer #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (launch),
        .busy     (busy),
        .erase_on (erase_on),
        .prog_on  (prog_on)
    );

    p_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !access_en);

    p_phase_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_on, prog_on}));

    p_fire_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        code_fire |=> erase_on);

    p_pf_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_rise && !busy) |=> erase_on);

endmodule

// File: tb/sim_nv_store_trigger.sv
module sim_nv_store_trigger;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 13;
    localparam int EC = 5;
    localparam int PC = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic          acc_we = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          pwr_fail = 1'b0;
    logic          access_en, busy, erase_on, prog_on;

    int checks = 0;
    int errors = 0;
    int m_step = 0;
    bit done = 1'b0;

    nv_store_trigger #(.ADDR_W(AW), .ERASE_CYC(EC), .PROG_CYC(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
        .acc_addr(acc_addr), .pwr_fail(pwr_fail), .access_en(access_en),
        .busy(busy), .erase_on(erase_on), .prog_on(prog_on)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [AW-1:0] key(input int i);
        case (i)
            0: return AW'(16'h0000);
            1: return AW'(16'h1555);
            2: return AW'(16'h0AAA);
            3: return AW'(16'h1FFF);
            4: return AW'(16'h10F0);
            default: return AW'(16'h0F0F);
        endcase
    endfunction

    // Reference model: returns 1 when the access completes the code
    function automatic bit model_step(input bit we, input logic [AW-1:0] a);
        bit f = 1'b0;
        if (!we && a == key(m_step)) begin
            if (m_step == 5) begin f = 1'b1; m_step = 0; end
            else m_step = m_step + 1;
        end else if (!we && a == key(0)) m_step = 1;
        else m_step = 0;
        return f;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Raw strobe, called at a negedge; returns at the next negedge
    task automatic pulse(input bit we, input logic [AW-1:0] a);
        acc_valid = 1'b1; acc_we = we; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0; acc_we = 1'b0;
    endtask

    task automatic measure_store(input string req);
        int e = 0, p = 0;
        while (erase_on && e < 1000) begin e++; @(negedge clk); end
        while (prog_on && p < 1000) begin p++; @(negedge clk); end
        check({req, "/R4 erase length"}, e, EC);
        check({req, "/R4 program length"}, p, PC);
        check({req, "/R8 access restored"}, int'(access_en), 1);
    endtask

    // Modelled access with checking
    task automatic access(input bit we, input logic [AW-1:0] a, input string req);
        bit f;
        pulse(we, a);
        f = model_step(we, a);
        check({req, " busy"}, int'(busy), int'(f));
        if (f) begin
            check({req, "/R1 erase starts"}, int'(erase_on), 1);
            measure_store(req);
        end
    endtask

    task automatic full_code(input string req);
        for (int i = 0; i < 6; i++) access(1'b0, key(i), req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset state
        check("R7 busy", int'(busy), 0);
        check("R7 erase", int'(erase_on), 0);
        check("R7 prog", int'(prog_on), 0);
        check("R7 access_en", int'(access_en), 1);

        // R1: plain code
        full_code("R1");
        // R8: second save after the first
        full_code("R8");

        // R2: write in the middle of the code
        for (int i = 0; i < 3; i++) access(1'b0, key(i), "R2");
        access(1'b1, key(3), "R2");
        for (int i = 3; i < 6; i++) access(1'b0, key(i), "R2");
        // R2: write to the final word address
        for (int i = 0; i < 5; i++) access(1'b0, key(i), "R2");
        access(1'b1, key(5), "R2");

        // R3: stray read aborts; read of first word restarts at step one
        for (int i = 0; i < 4; i++) access(1'b0, key(i), "R3");
        access(1'b0, AW'(16'h0123), "R3");
        access(1'b0, key(4), "R3");
        for (int i = 0; i < 3; i++) access(1'b0, key(i), "R3");
        access(1'b0, key(0), "R3");
        for (int i = 1; i < 6; i++) access(1'b0, key(i), "R3");

        // R5: strobes during a save are ignored
        for (int i = 0; i < 6; i++) pulse(1'b0, key(i));
        check("R5 busy after code", int'(busy), 1);
        check("R5 access_en low", int'(access_en), 0);
        for (int i = 0; i < 3; i++) pulse(1'b0, key(i));
        while (busy) @(negedge clk);
        for (int i = 3; i < 6; i++) begin
            pulse(1'b0, key(i));
            check("R5 no save from stale progress", int'(busy), 0);
        end
        m_step = 0;

        // R6 + R9: supply fail mid-code
        for (int i = 0; i < 3; i++) access(1'b0, key(i), "R6");
        pwr_fail = 1'b1;
        @(negedge clk);
        check("R6 auto save", int'(erase_on), 1);
        check("R6 access blocked", int'(access_en), 0);
        pulse(1'b0, key(3));
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R9 no second save", int'(busy), 0);
        check("R6 still blocked", int'(access_en), 0);
        pwr_fail = 1'b0;
        @(negedge clk);
        check("R6 access back", int'(access_en), 1);
        m_step = 0;
        for (int i = 3; i < 6; i++) access(1'b0, key(i), "R6 progress discarded");
        full_code("R6");

        // R1/R2/R3: constrained random stream
        for (int n = 0; n < 600; n++) begin
            int r = int'($urandom_range(99));
            bit we = ($urandom_range(99) < 8);
            logic [AW-1:0] a;
            if (r < 65)      a = key(m_step);
            else if (r < 78) a = key(0);
            else if (r < 88) a = key(int'($urandom_range(5)));
            else             a = AW'($urandom);
            access(we, a, "R1/R2/R3 random");
            if ($urandom_range(9) == 0) @(negedge clk);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule